// File: doc/BRIEF.md
# Multi-Mode Timer/Counter

A timer/counter of parameterizable width (8 to 16 bits) that advances on ticks from a shared prescaler. A four-bit waveform mode selects how the counter finds its upper limit (TOP) and how it behaves at that limit. TOP can be a fixed all-ones value, compare register A, or the capture register. The modes cover free running, clear-on-match, fast PWM at 8, 9 and 10 bits, and PWM with a register-defined period. Two compare channels produce single-cycle event strobes and a pair of pulse-width outputs. In normal and fast-PWM modes a wrap strobe marks each wrap.

Software programs the block through a byte-wide write port. Wide registers are written as a pair of bytes: the high byte is parked in a holding register, and the write to the low-byte address commits the whole value. Any change to the clock-select or mode bits restarts the prescaler and the counter. In modes with buffered duty values, the duty and the register-A TOP reload only when the counter wraps.

Top module: `mode_timer`

## Requirements
- R1: Address map: 0 control, 2/3 counter low/high, 4/5 compare A low/high, 6/7 compare B low/high, 8/9 capture low/high. A write to a high-byte (odd) address only loads a holding byte and changes no register. A write to the low-byte (even) address commits {holding byte, data}, truncated to CNT_W bits.
- R2: Control byte bits [2:0] are the clock select and bits [6:3] are the mode. Clock-select codes 1, 2, 3, 4 and 5 produce a tick every 1, 8, 64, 256 and 1024 cycles. Codes 0, 6 and 7 produce no ticks.
- R3: Mode 0 counts up to TOP = 2^CNT_W-1, then returns to 0. Each wrap produces a one-cycle overflow strobe.
- R4: Modes 4 and 12 clear on match, with TOP taken from compare A and from the capture register respectively. They produce no overflow strobe.
- R5: Modes 5, 6 and 7 are fast PWM with TOP of 255, 511 and 1023, and produce overflow strobes. A mode whose fixed TOP needs more than CNT_W bits is unsupported.
- R6: Modes 14 and 15 are PWM with TOP from the capture register and from compare A respectively. They produce no overflow strobe.
- R7: A compare strobe for channel A or B is high for one cycle, in the cycle after a tick edge at which the counter equalled that channel's value. It fires only if that value is nonzero and not greater than TOP.
- R8: In modes 5, 6, 7, 14 and 15 each PWM output is high while the counter is below its duty value and low otherwise, so a duty of 0 keeps the output low. In all other modes both PWM outputs are low.
- R9: In the PWM modes, the duty values (and TOP in mode 15) reload from compare A and B only at a wrap tick or on a reconfiguration. Writes between wraps do not affect the current period.
- R10: A control write that changes the clock-select or mode bits clears the counter on the next edge and restarts the prescaler. The first tick then arrives one full division period later.
- R11: A mode code outside {0, 4, 5, 6, 7, 12, 14, 15} stops the counter.
- R12: If TOP is lowered below the current count, the counter keeps counting up to all ones and wraps through 0.
- R13: A committed counter write loads the counter directly and takes precedence over a tick in the same cycle.
- R14: After reset the counter, the strobes and the PWM outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register byte address |
| wr_data | input | 8 | Write data byte |
| count | output | CNT_W | Current counter value |
| ovf_stb | output | 1 | Wrap strobe (normal and fast-PWM modes) |
| cmpa_stb | output | 1 | Compare A event strobe |
| cmpb_stb | output | 1 | Compare B event strobe |
| pwm_a | output | 1 | PWM output, channel A |
| pwm_b | output | 1 | PWM output, channel B |

## Verification
The bench builds two instances. One uses CNT_W=16; with it, every mode, every divide ratio, the 9- and 10-bit fast-PWM limits and the register-defined periods can be reached in a few thousand cycles. The other uses CNT_W=8. It reaches the all-ones wrap of the normal mode within 300 cycles and exposes the rule that a fast-PWM width wider than the counter is refused. Strobe counts are compared against counts derived from the tick count and TOP, so the boundary between one period and the next is checked exactly.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int PRE_W = 10;

  typedef enum logic [2:0] {K_NONE, K_NORMAL, K_CTC, K_PWM, K_FAST} kind_e;
  typedef enum logic [1:0] {T_FIXED, T_CMPA, T_CAPT} topsrc_e;

  typedef struct packed {
    kind_e      kind;
    topsrc_e    src;
    logic [4:0] bits;
  } mode_t;

  // Mode code to counting behaviour; widths beyond the counter are refused.
  function automatic mode_t decode_mode(input logic [3:0] code, input int cnt_w);
    mode_t m;
    m = '{kind: K_NONE, src: T_FIXED, bits: 5'd0};
    case (code)
      4'd0:  m = '{kind: K_NORMAL, src: T_FIXED, bits: 5'(cnt_w)};
      4'd4:  m = '{kind: K_CTC,    src: T_CMPA,  bits: 5'd0};
      4'd12: m = '{kind: K_CTC,    src: T_CAPT,  bits: 5'd0};
      4'd5:  m = '{kind: K_FAST,   src: T_FIXED, bits: 5'd8};
      4'd6:  m = '{kind: K_FAST,   src: T_FIXED, bits: 5'd9};
      4'd7:  m = '{kind: K_FAST,   src: T_FIXED, bits: 5'd10};
      4'd14: m = '{kind: K_PWM,    src: T_CAPT,  bits: 5'd0};
      4'd15: m = '{kind: K_PWM,    src: T_CMPA,  bits: 5'd0};
      default: m.kind = K_NONE;
    endcase
    if (int'(m.bits) > cnt_w) m.kind = K_NONE;
    return m;
  endfunction

  function automatic logic cs_runs(input logic [2:0] cs);
    return (cs >= 3'd1) && (cs <= 3'd5);
  endfunction

  // Low prescaler bits that must all be ones for a tick.
  function automatic logic [PRE_W-1:0] div_mask(input logic [2:0] cs);
    case (cs)
      3'd2:    return PRE_W'(10'h007);
      3'd3:    return PRE_W'(10'h03F);
      3'd4:    return PRE_W'(10'h0FF);
      3'd5:    return PRE_W'(10'h3FF);
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cs,
  input  logic       restart,
  output logic       tick
);
  logic [PRE_W-1:0] pcnt;
  logic [PRE_W-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt <= '0;
    else if (restart) pcnt <= '0;
    else              pcnt <= pcnt + 1'b1;
  end

  assign mask = div_mask(cs);
  assign tick = cs_runs(cs) && ((pcnt & mask) == mask);
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       wr_addr,
  input  logic [7:0]       wr_data,
  output logic [2:0]       cs,
  output logic [3:0]       mode,
  output logic             cfg_chg,
  output logic [CNT_W-1:0] cmpa,
  output logic [CNT_W-1:0] cmpb,
  output logic [CNT_W-1:0] capt,
  output logic             cnt_wr,
  output logic [CNT_W-1:0] cnt_wval
);
  localparam logic [3:0] AD_CTRL = 4'd0;
  localparam logic [3:0] AD_CNT  = 4'd2;
  localparam logic [3:0] AD_CMPA = 4'd4;
  localparam logic [3:0] AD_CMPB = 4'd6;
  localparam logic [3:0] AD_CAPT = 4'd8;

  logic [7:0]       hold_q;
  logic [15:0]      wide;
  logic [CNT_W-1:0] wval;

  assign wide = {hold_q, wr_data};
  assign wval = wide[CNT_W-1:0];

  assign cnt_wr   = wr_en && (wr_addr == AD_CNT);
  assign cnt_wval = wval;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      cs      <= '0;
      mode    <= '0;
      cfg_chg <= 1'b0;
      cmpa    <= '0;
      cmpb    <= '0;
      capt    <= '0;
    end else begin
      cfg_chg <= 1'b0;
      if (wr_en) begin
        if (wr_addr[0]) hold_q <= wr_data;
        case (wr_addr)
          AD_CTRL: begin
            cs      <= wr_data[2:0];
            mode    <= wr_data[6:3];
            cfg_chg <= (wr_data[6:0] != {mode, cs});
          end
          AD_CMPA: cmpa <= wval;
          AD_CMPB: cmpb <= wval;
          AD_CAPT: capt <= wval;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_raw,
  input  logic             cfg_chg,
  input  logic [3:0]       mode,
  input  logic [CNT_W-1:0] cmpa,
  input  logic [CNT_W-1:0] cmpb,
  input  logic [CNT_W-1:0] capt,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wval,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf_stb,
  output logic             cmpa_stb,
  output logic             cmpb_stb,
  output logic             pwm_a,
  output logic             pwm_b,
  output logic             tick,
  output logic [CNT_W-1:0] top,
  output logic [CNT_W-1:0] cmpa_eff,
  output logic [CNT_W-1:0] duty_a,
  output logic             pwm_en
);
  function automatic logic [CNT_W-1:0] ones_below(input logic [4:0] b);
    logic [CNT_W-1:0] r;
    for (int i = 0; i < CNT_W; i++) r[i] = (i < int'(b));
    return r;
  endfunction

  mode_t            m;
  logic [CNT_W-1:0] duty_b;
  logic [CNT_W-1:0] cmpb_eff;
  logic             wrap;
  logic             en_a;
  logic             en_b;
  logic             has_ovf;

  assign m       = decode_mode(mode, CNT_W);
  assign pwm_en  = (m.kind == K_PWM) || (m.kind == K_FAST);
  assign has_ovf = (m.kind == K_NORMAL) || (m.kind == K_FAST);
  assign tick    = tick_raw && (m.kind != K_NONE) && !cfg_chg && !cnt_wr;

  always_comb begin
    case (m.src)
      T_CMPA:  top = pwm_en ? duty_a : cmpa;
      T_CAPT:  top = capt;
      default: top = ones_below(m.bits);
    endcase
  end

  assign cmpa_eff = pwm_en ? duty_a : cmpa;
  assign cmpb_eff = pwm_en ? duty_b : cmpb;
  assign wrap     = (cnt == top);
  assign en_a     = (cmpa_eff != '0) && (cmpa_eff <= top);
  assign en_b     = (cmpb_eff != '0) && (cmpb_eff <= top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      duty_a   <= '0;
      duty_b   <= '0;
      ovf_stb  <= 1'b0;
      cmpa_stb <= 1'b0;
      cmpb_stb <= 1'b0;
    end else if (cfg_chg) begin
      cnt      <= '0;
      duty_a   <= cmpa;
      duty_b   <= cmpb;
      ovf_stb  <= 1'b0;
      cmpa_stb <= 1'b0;
      cmpb_stb <= 1'b0;
    end else begin
      ovf_stb  <= tick && wrap && has_ovf;
      cmpa_stb <= tick && en_a && (cnt == cmpa_eff);
      cmpb_stb <= tick && en_b && (cnt == cmpb_eff);
      if (cnt_wr)    cnt <= cnt_wval;
      else if (tick) cnt <= wrap ? '0 : cnt + 1'b1;
      if (!pwm_en || (tick && wrap)) begin
        duty_a <= cmpa;
        duty_b <= cmpb;
      end
    end
  end

  assign pwm_a = pwm_en && (cnt < duty_a);
  assign pwm_b = pwm_en && (cnt < duty_b);
endmodule

// File: rtl/mode_timer.sv
module mode_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       wr_addr,
  input  logic [7:0]       wr_data,
  output logic [CNT_W-1:0] count,
  output logic             ovf_stb,
  output logic             cmpa_stb,
  output logic             cmpb_stb,
  output logic             pwm_a,
  output logic             pwm_b
);
  logic [2:0]       cs_w;
  logic [3:0]       mode_w;
  logic             cfg_chg_w;
  logic [CNT_W-1:0] cmpa_w, cmpb_w, capt_w;
  logic             cnt_wr_w;
  logic [CNT_W-1:0] cnt_wval_w;
  logic             tick_raw_w;
  logic             tick_w;
  logic [CNT_W-1:0] top_w;
  logic [CNT_W-1:0] cmpa_eff_w;
  logic [CNT_W-1:0] duty_a_w;
  logic             pwm_en_w;

  tmr_regs #(.CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cs(cs_w), .mode(mode_w), .cfg_chg(cfg_chg_w),
    .cmpa(cmpa_w), .cmpb(cmpb_w), .capt(capt_w),
    .cnt_wr(cnt_wr_w), .cnt_wval(cnt_wval_w)
  );

  tmr_prescale pre_i (
    .clk(clk), .rst_n(rst_n), .cs(cs_w), .restart(cfg_chg_w), .tick(tick_raw_w)
  );

  tmr_core #(.CNT_W(CNT_W)) core_i (
    .clk(clk), .rst_n(rst_n), .tick_raw(tick_raw_w), .cfg_chg(cfg_chg_w),
    .mode(mode_w), .cmpa(cmpa_w), .cmpb(cmpb_w), .capt(capt_w),
    .cnt_wr(cnt_wr_w), .cnt_wval(cnt_wval_w),
    .cnt(count), .ovf_stb(ovf_stb), .cmpa_stb(cmpa_stb), .cmpb_stb(cmpb_stb),
    .pwm_a(pwm_a), .pwm_b(pwm_b),
    .tick(tick_w), .top(top_w), .cmpa_eff(cmpa_eff_w), .duty_a(duty_a_w),
    .pwm_en(pwm_en_w)
  );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       cs,
  input logic             tick,
  input logic             cfg_chg,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] top,
  input logic [CNT_W-1:0] cmpa_eff,
  input logic [CNT_W-1:0] duty_a,
  input logic             pwm_en,
  input logic             ovf_stb,
  input logic             cmpa_stb,
  input logic             pwm_a,
  input logic             pwm_b
);
  a_r2_halt_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (cs == 3'd0 || cs > 3'd5) |-> !tick);

  a_r10_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> (count == '0));

  a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cfg_chg && !cnt_wr) |=> $stable(count));

  a_r3_ovf_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_stb |-> (count == '0));

  a_r7_cmpa_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cmpa_stb |-> ($past(cmpa_eff) != '0 && $past(cmpa_eff) <= $past(top)));

  a_r8_pwm_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_en |-> (!pwm_a && !pwm_b));

  a_r9_duty_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en && $past(pwm_en) && !$past(cfg_chg) &&
     !($past(tick) && $past(count) == $past(top))) |-> $stable(duty_a));
endmodule

bind mode_timer tmr_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs(cs_w), .tick(tick_w), .cfg_chg(cfg_chg_w),
  .cnt_wr(cnt_wr_w), .count(count), .top(top_w), .cmpa_eff(cmpa_eff_w),
  .duty_a(duty_a_w), .pwm_en(pwm_en_w), .ovf_stb(ovf_stb), .cmpa_stb(cmpa_stb),
  .pwm_a(pwm_a), .pwm_b(pwm_b)
);

// File: tb/mode_timer_tb_top.sv
module mode_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_en8 = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;

  logic [15:0] count;
  logic        ovf_stb, cmpa_stb, cmpb_stb, pwm_a, pwm_b;
  logic [7:0]  count8;
  logic        ovf8, ca8, cb8, pa8, pb8;

  int total = 0, failed = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mode_timer #(.CNT_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count(count), .ovf_stb(ovf_stb), .cmpa_stb(cmpa_stb), .cmpb_stb(cmpb_stb),
    .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  mode_timer #(.CNT_W(8)) dut8_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en8), .wr_addr(wr_addr), .wr_data(wr_data),
    .count(count8), .ovf_stb(ovf8), .cmpa_stb(ca8), .cmpb_stb(cb8),
    .pwm_a(pa8), .pwm_b(pb8)
  );

  typedef struct packed {
    logic [3:0]  mode;
    logic [2:0]  cs;
    logic [15:0] a, b, capt, n, ecnt;
    logic [7:0]  eovf, ea, eb;
  } vec_t;

  localparam vec_t VECS [0:13] = '{
    '{4'd4,  3'd1, 16'd9,   16'd4, 16'd0, 16'd25,   16'd5,   8'd0, 8'd2, 8'd3},
    '{4'd12, 3'd1, 16'd3,   16'd7, 16'd6, 16'd20,   16'd6,   8'd0, 8'd3, 8'd0},
    '{4'd5,  3'd1, 16'd16,  16'd0, 16'd0, 16'd600,  16'd88,  8'd2, 8'd3, 8'd0},
    '{4'd6,  3'd1, 16'd256, 16'd0, 16'd0, 16'd600,  16'd88,  8'd1, 8'd1, 8'd0},
    '{4'd7,  3'd1, 16'd0,   16'd0, 16'd0, 16'd1500, 16'd476, 8'd1, 8'd0, 8'd0},
    '{4'd0,  3'd2, 16'd50,  16'd0, 16'd0, 16'd800,  16'd100, 8'd0, 8'd1, 8'd0},
    '{4'd0,  3'd3, 16'd0,   16'd0, 16'd0, 16'd700,  16'd10,  8'd0, 8'd0, 8'd0},
    '{4'd0,  3'd4, 16'd0,   16'd0, 16'd0, 16'd1100, 16'd4,   8'd0, 8'd0, 8'd0},
    '{4'd0,  3'd5, 16'd0,   16'd0, 16'd0, 16'd3000, 16'd2,   8'd0, 8'd0, 8'd0},
    '{4'd0,  3'd0, 16'd5,   16'd0, 16'd0, 16'd50,   16'd0,   8'd0, 8'd0, 8'd0},
    '{4'd0,  3'd6, 16'd5,   16'd0, 16'd0, 16'd50,   16'd0,   8'd0, 8'd0, 8'd0},
    '{4'd3,  3'd1, 16'd5,   16'd0, 16'd0, 16'd50,   16'd0,   8'd0, 8'd0, 8'd0},
    '{4'd14, 3'd1, 16'd3,   16'd7, 16'd7, 16'd19,   16'd3,   8'd0, 8'd2, 8'd2},
    '{4'd15, 3'd1, 16'd5,   16'd2, 16'd0, 16'd13,   16'd1,   8'd0, 8'd2, 8'd2}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Caller sits at a negedge; consumes exactly one rising edge.
  task automatic wr(input bit sel8, input logic [3:0] ad, input logic [7:0] d);
    wr_addr = ad;
    wr_data = d;
    if (sel8) wr_en8 = 1'b1; else wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en  = 1'b0;
    wr_en8 = 1'b0;
  endtask

  task automatic wr16(input logic [3:0] base, input logic [15:0] v);
    wr(1'b0, base + 4'd1, v[15:8]);
    wr(1'b0, base, v[7:0]);
  endtask

  task automatic step(input int k);
    for (int i = 0; i < k; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  function automatic string tag_of(input logic [3:0] md, input logic [2:0] cs);
    if (cs == 3'd0 || cs > 3'd5) return "R2 stopped";
    if (md == 4'd0) return (cs == 3'd1) ? "R3 normal" : "R2 divider";
    if (md == 4'd4 || md == 4'd12) return "R4 clear-on-match";
    if (md >= 4'd5 && md <= 4'd7) return "R5 fast pwm";
    if (md == 4'd14 || md == 4'd15) return "R6 pwm";
    return "R11 unsupported";
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R14: reset state
    check("R14 count", count, 0);
    check("R14 strobes", {ovf_stb, cmpa_stb, cmpb_stb}, 0);
    check("R14 pwm", {pwm_a, pwm_b}, 0);

    // Vector table
    for (int v = 0; v < 14; v++) begin
      int no, na, nb;
      vec_t t;
      t = VECS[v];
      no = 0; na = 0; nb = 0;
      wr(1'b0, 4'd0, 8'h00);
      wr16(4'd4, t.a);
      wr16(4'd6, t.b);
      wr16(4'd8, t.capt);
      wr16(4'd2, 16'd0);
      wr(1'b0, 4'd0, {1'b0, t.mode, t.cs});
      step(1);
      for (int i = 0; i < int'(t.n); i++) begin
        @(posedge clk);
        @(negedge clk);
        no += int'(ovf_stb);
        na += int'(cmpa_stb);
        nb += int'(cmpb_stb);
      end
      check({tag_of(t.mode, t.cs), " count"}, count, t.ecnt);
      check({tag_of(t.mode, t.cs), " overflow strobes"}, no, t.eovf);
      check("R7 compare A strobes", na, t.ea);
      check("R7 compare B strobes", nb, t.eb);
    end

    // PWM waveform and duty buffering: mode 14, TOP=9, A=4, B=0
    wr(1'b0, 4'd0, 8'h00);
    wr16(4'd4, 16'd4);
    wr16(4'd6, 16'd0);
    wr16(4'd8, 16'd9);
    wr(1'b0, 4'd0, {1'b0, 4'd14, 3'd1});
    step(1);
    check("R8 pwm_a high at zero", pwm_a, 1);
    check("R8 pwm_b low with duty 0", pwm_b, 0);
    step(2);
    check("R8 pwm_a high below duty", pwm_a, 1);
    wr(1'b0, 4'd5, 8'h00);
    wr(1'b0, 4'd4, 8'd8);
    check("R9 count mid-period", count, 4);
    check("R9 old duty still in use", pwm_a, 0);
    step(11);
    check("R9 count after wrap", count, 5);
    check("R9 new duty after wrap", pwm_a, 1);
    check("R8 pwm_b stays low", pwm_b, 0);

    // R12: TOP lowered below count in clear-on-match mode
    wr(1'b0, 4'd0, 8'h00);
    wr16(4'd4, 16'd100);
    wr(1'b0, 4'd0, {1'b0, 4'd4, 3'd1});
    step(51);
    check("R12 count before change", count, 50);
    wr(1'b0, 4'd5, 8'h00);
    wr(1'b0, 4'd4, 8'd20);
    step(10);
    check("R12 counts past new TOP", count, 62);
    check("R8 pwm low in clear-on-match", pwm_a, 0);

    // R10: reconfigure divider while running
    wr(1'b0, 4'd0, {1'b0, 4'd4, 3'd2});
    step(1);
    check("R10 cleared on change", count, 0);
    step(7);
    check("R10 no tick before full period", count, 0);
    step(1);
    check("R10 first tick after 8 cycles", count, 1);

    // R1 / R13: byte pair commit and counter write
    wr(1'b0, 4'd0, 8'h00);
    wr(1'b0, 4'd3, 8'h12);
    check("R1 high byte alone ignored", count, 0);
    wr(1'b0, 4'd2, 8'h34);
    check("R1 low byte commits pair", count, 16'h1234);
    wr(1'b0, 4'd0, 8'h01);
    step(6);
    check("R13 running count", count, 5);
    wr(1'b0, 4'd3, 8'h00);
    wr(1'b0, 4'd2, 8'hF0);
    check("R13 write overrides tick", count, 16'h00F0);
    step(1);
    check("R13 counting resumes", count, 16'h00F1);

    // 8-bit instance: normal wrap at 255, 9-bit fast PWM refused
    begin
      int n8;
      n8 = 0;
      wr(1'b1, 4'd0, 8'h01);
      step(1);
      for (int i = 0; i < 300; i++) begin
        @(posedge clk);
        @(negedge clk);
        n8 += int'(ovf8);
      end
      check("R3 8-bit count", count8, 44);
      check("R3 8-bit overflow strobes", n8, 1);
      wr(1'b1, 4'd0, {1'b0, 4'd6, 3'd1});
      step(21);
      check("R5 wide fast pwm refused on 8-bit", count8, 0);
      check("R11 refused mode holds", {pa8, pb8}, 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      failed++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule